// File: doc/BRIEF.md
# FP Unit Reservation and Latency Tracker

This block sits at the issue point of a floating-point pipeline. It holds a forward-looking occupancy picture of the FP add unit and a short booking table for the lower integer pipes. Each cycle it decides whether the FP instruction offered on a valid/ready handshake can start without a structural clash. Some operations hold the add unit for many cycles (divide, square root). A conditional move uses the add unit twice, four cycles apart. Stores and FP-to-integer transfers need a lower integer pipe two cycles after issue.

For every accepted instruction the block reports, one cycle later, the result latency a scheduler should assume. The latency depends on the operation class, the operand size and whether the consumer is an FP store or FP-to-integer transfer. Two cycles after a store or transfer is accepted, it raises a lower-pipe request. The integer side books lower pipes through a claim count for the same future cycle, and it always wins. A flush input drops every booking at once. Only one instruction is offered per cycle.

Top module: `fpu_resv_tracker`

## Requirements
- R1: After reset, res_valid and lo_req are 0 and in_ready is 1 for every class while int_lo_claim is 0.
- R2: Class code 0 (add/copy-sign/FP branch) and class code 1 (multiply) report latency 4, or 6 when in_fwd_xfer is 1. The report appears with res_valid in the cycle after acceptance, with res_class echoing the code.
- R3: Class code 2 (conditional move) reports latency 8, or 10 with in_fwd_xfer. It books the add unit in its issue cycle and again exactly 4 cycles later. An add-unit class offered 1, 2, 3 or 5 cycles after it is ready, and one offered 4 cycles after it is refused.
- R4: Class code 3 (divide) with in_dbl 0 reports latency 12 and holds the add unit for 9 cycles. With in_dbl 1 it reports 15 and holds the unit for 12 cycles. The add unit is free again exactly at the end of the hold. A divide whose hold would overlap a booked conditional-move second use is refused.
- R5: Class code 4 (square root) with in_dbl 0 reports latency 18 and holds the add unit for 15 cycles. With in_dbl 1 it reports 33 and holds the unit for 30 cycles.
- R6: A multiply is accepted while the add unit is held.
- R7: Class codes 5 (FP store) and 6 (FP-to-integer transfer) report latency 3. Each raises lo_req for exactly one cycle, two cycles after acceptance. res_xunit alternates between the two store units on successive stores or transfers.
- R8: A store or transfer is refused when int_lo_claim equals the lower-pipe count (2). A refused store or transfer leaves no booking: no result and no lo_req follow.
- R9: Class code 7 (FP load) reports latency 2. It is refused in a cycle whose lower pipes are all booked by earlier store claims plus integer claims, and accepted again the next cycle.
- R10: While flush is 1, in_ready is 0. After the flush every pending add-unit hold and lower-pipe booking is gone, including a pending lo_req.
- R11: res_valid is 1 only in the cycle after an accepted handshake. Cycles with in_valid low produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drops all pending bookings |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can issue this cycle |
| in_class | input | 3 | Operation class code |
| in_dbl | input | 1 | Double-precision operand size |
| in_fwd_xfer | input | 1 | Consumer is FP store or FP-to-integer transfer |
| int_lo_claim | input | 2 | Lower pipes the integer side books for two cycles ahead |
| res_valid | output | 1 | Latency report valid |
| res_lat | output | 6 | Result latency in cycles |
| res_class | output | 3 | Class of the reported instruction |
| res_xunit | output | 1 | Store unit used by a store or transfer |
| lo_req | output | 1 | Lower integer pipe request for this cycle |

## Verification
in_ready is combinational, so the bench checks it shortly after driving inputs, in the same cycle. The latency report, class echo and store-unit index are due one clock edge after acceptance and are sampled just after that edge. lo_req is due in the second cycle after acceptance, so the bench sweeps the cycles around it. Add-unit holds are swept offset by offset from 1 to the hold length after each long operation, using a readiness probe with in_valid low. This pins the first free cycle exactly.

// File: rtl/fpu_resv_pkg.sv
package fpu_resv_pkg;

  typedef enum logic [2:0] {
    FC_ADD   = 3'd0,
    FC_MUL   = 3'd1,
    FC_CMOV  = 3'd2,
    FC_DIV   = 3'd3,
    FC_SQRT  = 3'd4,
    FC_STORE = 3'd5,
    FC_FTOI  = 3'd6,
    FC_LOAD  = 3'd7
  } fp_class_e;

  localparam int RUN_W        = 6;
  localparam int CMOV_GAP     = 4;

  localparam int LAT_ARITH    = 4;
  localparam int LAT_ARITH_FX = 6;
  localparam int LAT_CMOV     = 8;
  localparam int LAT_CMOV_FX  = 10;
  localparam int LAT_DIV_S    = 12;
  localparam int LAT_DIV_D    = 15;
  localparam int LAT_SQRT_S   = 18;
  localparam int LAT_SQRT_D   = 33;
  localparam int LAT_XFER     = 3;
  localparam int LAT_LOAD     = 2;

  localparam int HOLD_DIV_S   = 9;
  localparam int HOLD_DIV_D   = 12;
  localparam int HOLD_SQRT_S  = 15;
  localparam int HOLD_SQRT_D  = 30;

endpackage

// File: rtl/fpu_resv_decode.sv
module fpu_resv_decode
  import fpu_resv_pkg::*;
#(
  parameter int LAT_W = 6
) (
  input  logic [2:0]       cls,
  input  logic             dbl,
  input  logic             fwd,
  output logic             use_add,
  output logic [RUN_W-1:0] add_run,
  output logic             add_echo,
  output logic             is_xfer,
  output logic             is_load,
  output logic [LAT_W-1:0] lat
);

  fp_class_e c;
  assign c = fp_class_e'(cls);

  always_comb begin
    use_add  = 1'b0;
    add_run  = '0;
    add_echo = 1'b0;
    is_xfer  = 1'b0;
    is_load  = 1'b0;
    lat      = '0;
    unique case (c)
      FC_ADD: begin
        use_add = 1'b1;
        add_run = RUN_W'(1);
        lat     = fwd ? LAT_W'(LAT_ARITH_FX) : LAT_W'(LAT_ARITH);
      end
      FC_MUL: begin
        lat = fwd ? LAT_W'(LAT_ARITH_FX) : LAT_W'(LAT_ARITH);
      end
      FC_CMOV: begin
        use_add  = 1'b1;
        add_run  = RUN_W'(1);
        add_echo = 1'b1;
        lat      = fwd ? LAT_W'(LAT_CMOV_FX) : LAT_W'(LAT_CMOV);
      end
      FC_DIV: begin
        use_add = 1'b1;
        add_run = dbl ? RUN_W'(HOLD_DIV_D) : RUN_W'(HOLD_DIV_S);
        lat     = dbl ? LAT_W'(LAT_DIV_D) : LAT_W'(LAT_DIV_S);
      end
      FC_SQRT: begin
        use_add = 1'b1;
        add_run = dbl ? RUN_W'(HOLD_SQRT_D) : RUN_W'(HOLD_SQRT_S);
        lat     = dbl ? LAT_W'(LAT_SQRT_D) : LAT_W'(LAT_SQRT_S);
      end
      FC_STORE, FC_FTOI: begin
        is_xfer = 1'b1;
        lat     = LAT_W'(LAT_XFER);
      end
      FC_LOAD: begin
        is_load = 1'b1;
        lat     = LAT_W'(LAT_LOAD);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fpu_add_window.sv
module fpu_add_window
  import fpu_resv_pkg::*;
#(
  parameter int WIN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fire,
  input  logic [RUN_W-1:0] run,
  input  logic             echo,
  output logic             free
);

  logic [WIN-1:0] busy;
  logic [WIN-1:0] need;

  for (genvar i = 0; i < WIN; i++) begin : g_need
    assign need[i] = (i < int'(run)) || (echo && (i == CMOV_GAP));
  end

  assign free = ~|(busy & need);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy <= '0;
    end else begin
      busy <= (busy | (fire ? need : '0)) >> 1;
    end
  end

  // R3: the second use of a conditional move survives the shift
  p_echo_kept_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(fire && echo) && !$past(flush)) |-> busy[CMOV_GAP-1]);

  // R5: a hold never reaches past the window
  p_run_fits_r5: assert property (@(posedge clk) disable iff (rst)
    fire |-> (int'(run) < WIN));

  // R10: a flush leaves the window empty
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (busy == '0));

endmodule

// File: rtl/fpu_lower_window.sv
module fpu_lower_window #(
  parameter int DELAY = 2,
  parameter int NLOW  = 2,
  parameter int CLW   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic [CLW-1:0] claim,
  input  logic           st_fire,
  output logic           st_ok,
  output logic           ld_ok
);

  localparam int CW = $clog2(NLOW + 2);

  logic [CW-1:0] cnt [DELAY];
  logic [CW-1:0] claim_c;

  assign claim_c = (int'(claim) > NLOW) ? CW'(NLOW) : CW'(claim);
  assign st_ok   = (int'(claim_c) + 1) <= NLOW;
  assign ld_ok   = int'(cnt[0]) < NLOW;

  for (genvar i = 0; i < DELAY; i++) begin : g_slot
    if (i == DELAY - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst || flush) cnt[i] <= '0;
        else              cnt[i] <= claim_c + CW'(st_fire);
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst || flush) cnt[i] <= '0;
        else              cnt[i] <= cnt[i+1];
      end
    end
  end

  // R9: bookings never exceed the lower pipe count
  p_lower_cap_r9: assert property (@(posedge clk) disable iff (rst)
    int'(cnt[0]) <= NLOW);

  // R8: a store is only taken with a pipe left for it
  p_store_room_r8: assert property (@(posedge clk) disable iff (rst)
    st_fire |-> (int'(claim_c) < NLOW));

endmodule

// File: rtl/fpu_resv_tracker.sv
module fpu_resv_tracker
  import fpu_resv_pkg::*;
#(
  parameter int ADD_WIN  = 32,
  parameter int LO_DELAY = 2,
  parameter int NUM_LOW  = 2,
  parameter int LAT_W    = 6,
  parameter int CLAIM_W  = $clog2(NUM_LOW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_class,
  input  logic               in_dbl,
  input  logic               in_fwd_xfer,
  input  logic [CLAIM_W-1:0] int_lo_claim,
  output logic               res_valid,
  output logic [LAT_W-1:0]   res_lat,
  output logic [2:0]         res_class,
  output logic               res_xunit,
  output logic               lo_req
);

  logic             use_add, add_echo, is_xfer, is_load;
  logic [RUN_W-1:0] add_run;
  logic [LAT_W-1:0] lat;
  logic             add_free, st_ok, ld_ok;
  logic             fire, st_fire;
  logic             xsel;
  logic [LO_DELAY-1:0] lo_pipe;

  fpu_resv_decode #(.LAT_W(LAT_W)) u_dec (
    .cls(in_class), .dbl(in_dbl), .fwd(in_fwd_xfer),
    .use_add(use_add), .add_run(add_run), .add_echo(add_echo),
    .is_xfer(is_xfer), .is_load(is_load), .lat(lat)
  );

  fpu_add_window #(.WIN(ADD_WIN)) u_add (
    .clk(clk), .rst(rst), .flush(flush),
    .fire(fire && use_add), .run(add_run), .echo(add_echo),
    .free(add_free)
  );

  fpu_lower_window #(.DELAY(LO_DELAY), .NLOW(NUM_LOW), .CLW(CLAIM_W)) u_low (
    .clk(clk), .rst(rst), .flush(flush),
    .claim(int_lo_claim), .st_fire(st_fire),
    .st_ok(st_ok), .ld_ok(ld_ok)
  );

  assign in_ready = !rst && !flush
                 && (!use_add || add_free)
                 && (!is_xfer || st_ok)
                 && (!is_load || ld_ok);
  assign fire    = in_valid && in_ready;
  assign st_fire = fire && is_xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_lat   <= '0;
      res_class <= '0;
      res_xunit <= 1'b0;
      xsel      <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_lat   <= lat;
        res_class <= in_class;
      end
      if (st_fire) begin
        res_xunit <= xsel;
        xsel      <= ~xsel;
      end
    end
  end

  if (LO_DELAY == 1) begin : g_lo1
    always_ff @(posedge clk) begin
      if (rst || flush) lo_pipe <= '0;
      else              lo_pipe <= st_fire;
    end
  end else begin : g_lon
    always_ff @(posedge clk) begin
      if (rst || flush) lo_pipe <= '0;
      else              lo_pipe <= {lo_pipe[LO_DELAY-2:0], st_fire};
    end
  end

  assign lo_req = lo_pipe[LO_DELAY-1];

  // R11: a report only follows an accepted handshake
  p_res_from_accept_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_ready));

  // R9: loads always report the short latency
  p_load_lat_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 3'(FC_LOAD)) |-> (res_lat == LAT_W'(LAT_LOAD)));

  if (LO_DELAY == 2) begin : g_chk2
    // R7: the lower pipe request comes from a store two cycles back
    p_lo_req_origin_r7: assert property (@(posedge clk) disable iff (rst)
      lo_req |-> $past(st_fire, 2));
  end

endmodule

// File: tb/fpu_resv_tracker_tb_top.sv
module fpu_resv_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_class = 3'd0;
  logic       in_dbl = 1'b0;
  logic       in_fwd_xfer = 1'b0;
  logic [1:0] int_lo_claim = 2'd0;
  logic       res_valid;
  logic [5:0] res_lat;
  logic [2:0] res_class;
  logic       res_xunit;
  logic       lo_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpu_resv_tracker dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_dbl(in_dbl), .in_fwd_xfer(in_fwd_xfer),
    .int_lo_claim(int_lo_claim),
    .res_valid(res_valid), .res_lat(res_lat), .res_class(res_class),
    .res_xunit(res_xunit), .lo_req(lo_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: offer an instruction, check readiness and the report
  task automatic issue(input int c, input bit d, input bit f, input int claim,
                       input bit exp_rdy, input int exp_lat, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'(c); in_dbl = d; in_fwd_xfer = f;
    int_lo_claim = 2'(claim);
    #1 chk(in_ready == exp_rdy, {tag, " ready"}, in_ready, exp_rdy);
    @(posedge clk); #1;
    chk(res_valid == exp_rdy, {tag, " res_valid"}, res_valid, exp_rdy);
    if (exp_rdy) begin
      chk(res_lat == 6'(exp_lat), {tag, " latency"}, res_lat, exp_lat);
      chk(res_class == 3'(c), {tag, " class"}, res_class, c);
    end
  endtask

  // one cycle with in_valid low: readiness and optionally lo_req
  task automatic probe(input int c, input bit exp_rdy, input int exp_lo, input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_class = 3'(c); in_dbl = 1'b0; in_fwd_xfer = 1'b0;
    int_lo_claim = 2'd0;
    #1 chk(in_ready == exp_rdy, {tag, " ready"}, in_ready, exp_rdy);
    if (exp_lo >= 0) chk(lo_req == 1'(exp_lo), {tag, " lo_req"}, lo_req, exp_lo);
    @(posedge clk); #1;
    chk(res_valid == 1'b0, {tag, " no result"}, res_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(lo_req == 1'b0, "R1 lo_req", lo_req, 0);
    for (int c = 0; c < 8; c++) begin
      in_class = 3'(c);
      #1 chk(in_ready == 1'b1, "R1 ready all classes", in_ready, 1);
    end

    // R2 add and multiply, plain and forwarding
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 2; f++)
        issue(c, 1'b0, 1'(f), 0, 1'b1, (f != 0) ? 6 : 4, "R2 arith");

    // R3 conditional move and its second add-unit use
    for (int f = 0; f < 2; f++) begin
      issue(2, 1'b0, 1'(f), 0, 1'b1, (f != 0) ? 10 : 8, "R3 cmov");
      for (int k = 1; k <= 5; k++) probe(0, k != 4, -1, "R3 cmov echo");
    end
    // R4 divide refused when its hold overlaps a cmov second use
    issue(2, 1'b0, 1'b0, 0, 1'b1, 8, "R3 cmov before div");
    issue(3, 1'b0, 1'b0, 0, 1'b0, 0, "R4 div overlaps cmov");
    probe(0, 1'b1, -1, "R4 gap");
    probe(0, 1'b1, -1, "R4 gap");
    probe(0, 1'b0, -1, "R4 cmov slot");
    issue(3, 1'b0, 1'b0, 0, 1'b1, 12, "R4 div after cmov");
    for (int k = 1; k <= 9; k++) probe(0, k >= 9, -1, "R4 div hold");

    // R4 and R5 holds, swept offset by offset
    for (int op = 0; op < 4; op++) begin
      int c;
      bit d;
      int hold;
      int l;
      c = (op < 2) ? 3 : 4;
      d = 1'(op % 2);
      hold = (op == 0) ? 9 : (op == 1) ? 12 : (op == 2) ? 15 : 30;
      l = (op == 0) ? 12 : (op == 1) ? 15 : (op == 2) ? 18 : 33;
      issue(c, d, 1'b0, 0, 1'b1, l, (c == 3) ? "R4 divide" : "R5 sqrt");
      for (int k = 1; k <= hold; k++)
        probe(2, k >= hold, -1, (c == 3) ? "R4 hold sweep" : "R5 hold sweep");
    end

    // R6 multiply during an add-unit hold
    issue(3, 1'b1, 1'b0, 0, 1'b1, 15, "R6 div");
    probe(0, 1'b0, -1, "R6 add busy");
    issue(1, 1'b0, 1'b1, 0, 1'b1, 6, "R6 mul while busy");
    for (int k = 3; k <= 12; k++) probe(1, 1'b1, -1, "R6 mul ready");

    // R7 store and transfer: latency, unit alternation, lo_req timing
    begin
      logic first_unit;
      issue(5, 1'b0, 1'b0, 0, 1'b1, 3, "R7 store");
      first_unit = res_xunit;
      probe(0, 1'b1, 0, "R7 lo_req t+1");
      probe(0, 1'b1, 1, "R7 lo_req t+2");
      probe(0, 1'b1, 0, "R7 lo_req t+3");
      issue(6, 1'b0, 1'b0, 0, 1'b1, 3, "R7 ftoi");
      chk(res_xunit == ~first_unit, "R7 unit alternates", res_xunit, !first_unit);
      issue(5, 1'b0, 1'b0, 0, 1'b1, 3, "R7 store again");
      chk(res_xunit == first_unit, "R7 unit alternates back", res_xunit, first_unit);
      probe(0, 1'b1, 1, "R7 lo_req ftoi");
      probe(0, 1'b1, 1, "R7 lo_req store");
      probe(0, 1'b1, 0, "R7 lo_req idle");
    end

    // R9 load blocked by store plus integer claim
    issue(5, 1'b0, 1'b0, 1, 1'b1, 3, "R9 store with claim");
    probe(7, 1'b1, 0, "R9 load t+1");
    probe(7, 1'b0, 1, "R9 load t+2 full");
    issue(7, 1'b0, 1'b0, 0, 1'b1, 2, "R9 load t+3");

    // R8 store refused under a full integer claim, no trace left
    issue(6, 1'b0, 1'b0, 2, 1'b0, 0, "R8 ftoi refused");
    probe(0, 1'b1, 0, "R8 no lo_req t+1");
    probe(7, 1'b0, 0, "R8 no lo_req t+2");
    probe(7, 1'b1, 0, "R8 load after");
    issue(5, 1'b0, 1'b0, 1, 1'b1, 3, "R8 store under partial claim");
    probe(0, 1'b1, 0, "R8 t+1");
    probe(0, 1'b1, 1, "R8 t+2");

    // R10 flush drops holds and a pending lo_req
    issue(4, 1'b1, 1'b0, 0, 1'b1, 33, "R10 sqrt");
    issue(5, 1'b0, 1'b0, 0, 1'b1, 3, "R10 store");
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'd1; flush = 1'b1;
    #1 chk(in_ready == 1'b0, "R10 ready during flush", in_ready, 0);
    @(posedge clk); #1;
    chk(res_valid == 1'b0, "R10 no result in flush", res_valid, 0);
    @(negedge clk); flush = 1'b0; in_valid = 1'b0;
    probe(0, 1'b1, 0, "R10 add free, lo_req cancelled");
    issue(4, 1'b0, 1'b0, 0, 1'b1, 18, "R10 sqrt after flush");

    // R11 idle cycles produce nothing
    for (int k = 0; k < 3; k++) probe(1, 1'b1, 0, "R11 idle");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule